// File: doc/BRIEF.md
# Phase-Domain Digital PLL Loop Core

This block is the arithmetic heart of an all-digital frequency synthesizer loop. It runs entirely on the retimed reference clock. On each cycle where `refValid` marks a retimed reference edge, it advances two counters. The reference phase is a fixed-point accumulator that grows by the frequency command word plus the modulation word. The variable phase is an integer count that grows by the number of oscillator rising edges seen in that reference period. Because both values live in one clock domain, the phase error is an exact two's-complement subtraction. It is refined by the fractional reading of a time-to-digital converter, so its resolution is finer than one oscillator period.

The error then passes through a proportional-plus-integral filter. The proportional and integral gains are programmable right shifts, and the integrator saturates. The modulation word is added directly onto the control path, and the filter output is scaled by a programmable inverse oscillator gain. The result, offset by a centre value, becomes the saturated oscillator tuning word. The modulation word is also fed into the reference accumulator. This feeds the frequency step straight to the oscillator and also tells the loop to expect it, so the loop does not fight the modulation.

Top module: `dpll_phase_core`

## Requirements
- R1: While `rst` is high at a clock edge, all accumulators and the integrator are cleared, `otw` becomes OTW_CENTER (256 by default) and `phaseErr` becomes 0. Both outputs keep these values until one cycle after the first `refValid` edge.
- R2: When `refValid` is low, no state changes. `otw` and `phaseErr` stay stable whatever `fcw`, `edgeInc`, `tdcFrac`, `modWord`, the shifts or `invGain` do.
- R3: A `refValid` cycle adds `fcw` + `modWord` to the reference phase and `edgeInc` to the variable phase. `fcw` is unsigned with FRAC_W fractional bits. `modWord` is two's complement in the same format. `edgeInc` is an unsigned integer. One cycle later, `phaseErr` equals reference phase − variable phase·2^FRAC_W + `tdcFrac`, taken modulo 2^(INT_W+FRAC_W).
- R4: Both phases wrap modulo their widths. When the reference and oscillator rates match, `phaseErr` stays exact across any number of wraps.
- R5: `tdcFrac` is an unsigned fraction worth 2^-FRAC_W of an oscillator period per LSB. It is added to the error's fractional bits.
- R6: The proportional term is the signed error arithmetically right-shifted by `kpShift`, which rounds toward minus infinity.
- R7: Each `refValid` cycle adds the signed error, arithmetically right-shifted by `kiShift`, to the integrator.
- R8: The integrator saturates at ±(2^(INTEG_W−1)) limits: the maximum is 2^(INTEG_W−1)−1 and the minimum is −2^(INTEG_W−1). It never wraps.
- R9: `otw` = OTW_CENTER + floor((integrator + proportional term + modWord)·`invGain` / 2^GAIN_FRAC). This value is saturated to the signed OTW_W range. An `invGain` of 0 gives OTW_CENTER.
- R10: `modWord` reaches `otw` on the tuning path in the same update as it enters the reference phase.
- R11: Asserting `rst` mid-run restores the R1 state. The following steps behave exactly as they do after a power-up reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Retimed reference clock |
| rst | input | 1 | Synchronous reset, active high |
| refValid | input | 1 | Marks a retimed reference edge cycle |
| fcw | input | INT_W+FRAC_W | Frequency command word, unsigned fixed point |
| edgeInc | input | EDGE_W | Oscillator rising edges in this reference period |
| tdcFrac | input | FRAC_W | Fractional phase correction from the delay-line converter |
| modWord | input | INT_W+FRAC_W | Signed feed-forward modulation word |
| kpShift | input | SHIFT_W | Proportional gain as a right shift |
| kiShift | input | SHIFT_W | Integral gain as a right shift |
| invGain | input | GAIN_W | Inverse oscillator gain, GAIN_FRAC fractional bits |
| phaseErr | output | INT_W+FRAC_W | Registered two's-complement phase error |
| otw | output | OTW_W | Signed oscillator tuning word |

## Verification
A corrupted phase accumulator shows up on `phaseErr` one cycle after the next `refValid` and stays wrong on every later step, because the error is never re-derived from anything else. A corrupted integrator leaves `phaseErr` correct, but it skews `otw` from the next update onward. Holding the error constant separates that skew from the proportional path. Saturation faults show only after a long run of same-sign errors, so the run is driven to both integrator limits and then pushed one step further. Wraparound faults show only after the integer phase passes 2^INT_W, so a matched-rate run of twenty steps crosses that boundary.

// File: rtl/dpll_phase_core_pkg.sv
package dpll_phase_core_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic accum;
    logic filt;
  } loopStb_t;
endpackage

// File: rtl/dpll_phase_ctrl.sv
module dpll_phase_ctrl
  import dpll_phase_core_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     refValid,
  output loopStb_t stb
);
  logic filtPend;

  always_ff @(posedge clk) begin
    if (rst) filtPend <= 1'b0;
    else     filtPend <= refValid;
  end

  always_comb begin
    stb.clear = rst;
    stb.accum = refValid & ~rst;
    stb.filt  = filtPend & ~rst;
  end
endmodule

// File: rtl/dpll_phase_dp.sv
module dpll_phase_dp
  import dpll_phase_core_pkg::*;
#(
  parameter int INT_W      = 8,
  parameter int FRAC_W     = 4,
  parameter int EDGE_W     = 4,
  parameter int SHIFT_W    = 3,
  parameter int GAIN_W     = 8,
  parameter int GAIN_FRAC  = 4,
  parameter int INTEG_W    = 16,
  parameter int OTW_W      = 14,
  parameter int OTW_CENTER = 256,
  parameter int PH_W       = INT_W + FRAC_W
) (
  input  logic                      clk,
  input  loopStb_t                  stb,
  input  logic [PH_W-1:0]           fcw,
  input  logic [EDGE_W-1:0]         edgeInc,
  input  logic [FRAC_W-1:0]         tdcFrac,
  input  logic signed [PH_W-1:0]    modWord,
  input  logic [SHIFT_W-1:0]        kpShift,
  input  logic [SHIFT_W-1:0]        kiShift,
  input  logic [GAIN_W-1:0]         invGain,
  output logic [PH_W-1:0]           phaseErr,
  output logic signed [OTW_W-1:0]   otw,
  output logic signed [INTEG_W-1:0] integVal,
  output logic [PH_W-1:0]           phErrNow
);
  localparam int CTRL_W = INTEG_W + 2;
  localparam int PROD_W = CTRL_W + GAIN_W + 1;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [INTEG_W:0] INTEG_HI = (INTEG_W+1)'((2**(INTEG_W-1)) - 1);
  localparam logic signed [INTEG_W:0] INTEG_LO = (INTEG_W+1)'(-(2**(INTEG_W-1)));
  localparam logic signed [SUM_W-1:0] OTW_HI   = SUM_W'((2**(OTW_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] OTW_LO   = SUM_W'(-(2**(OTW_W-1)));
  localparam logic signed [SUM_W-1:0] CENTER_X = SUM_W'(OTW_CENTER);

  logic [PH_W-1:0]          refAcc;
  logic [INT_W-1:0]         varAcc;
  logic [FRAC_W-1:0]        tdcReg;
  logic signed [PH_W-1:0]   modReg;

  // Phase accumulators, both wrap modulo their widths
  always_ff @(posedge clk) begin
    if (stb.clear) begin
      refAcc <= '0;
      varAcc <= '0;
      tdcReg <= '0;
      modReg <= '0;
    end else if (stb.accum) begin
      refAcc <= refAcc + fcw + modWord;
      varAcc <= varAcc + INT_W'(edgeInc);
      tdcReg <= tdcFrac;
      modReg <= modWord;
    end
  end

  // Exact two's-complement phase detector
  assign phErrNow = refAcc - {varAcc, {FRAC_W{1'b0}}} + PH_W'(tdcReg);

  logic signed [PH_W-1:0]    errS, propTerm, intTerm;
  logic signed [INTEG_W:0]   integSum;
  logic signed [INTEG_W-1:0] integNew;
  logic signed [CTRL_W-1:0]  ctrlSum;
  logic signed [PROD_W-1:0]  prod, scaled;
  logic signed [SUM_W-1:0]   otwSum;
  logic signed [OTW_W-1:0]   otwNext;

  always_comb begin
    errS     = $signed(phErrNow);
    propTerm = errS >>> kpShift;
    intTerm  = errS >>> kiShift;
    integSum = (INTEG_W+1)'(integVal) + (INTEG_W+1)'(intTerm);
    if (integSum > INTEG_HI)      integNew = INTEG_HI[INTEG_W-1:0];
    else if (integSum < INTEG_LO) integNew = INTEG_LO[INTEG_W-1:0];
    else                          integNew = integSum[INTEG_W-1:0];
    ctrlSum = CTRL_W'(integNew) + CTRL_W'(propTerm) + CTRL_W'(modReg);
    prod    = PROD_W'(ctrlSum) * PROD_W'($signed({1'b0, invGain}));
    scaled  = prod >>> GAIN_FRAC;
    otwSum  = SUM_W'(scaled) + CENTER_X;
    if (otwSum > OTW_HI)      otwNext = OTW_HI[OTW_W-1:0];
    else if (otwSum < OTW_LO) otwNext = OTW_LO[OTW_W-1:0];
    else                      otwNext = otwSum[OTW_W-1:0];
  end

  // Loop filter state and outputs
  always_ff @(posedge clk) begin
    if (stb.clear) begin
      integVal <= '0;
      phaseErr <= '0;
      otw      <= OTW_W'(OTW_CENTER);
    end else if (stb.filt) begin
      integVal <= integNew;
      phaseErr <= phErrNow;
      otw      <= otwNext;
    end
  end
endmodule

// File: rtl/dpll_phase_core.sv
module dpll_phase_core
  import dpll_phase_core_pkg::*;
#(
  parameter int INT_W      = 8,
  parameter int FRAC_W     = 4,
  parameter int EDGE_W     = 4,
  parameter int SHIFT_W    = 3,
  parameter int GAIN_W     = 8,
  parameter int GAIN_FRAC  = 4,
  parameter int INTEG_W    = 16,
  parameter int OTW_W      = 14,
  parameter int OTW_CENTER = 256
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              refValid,
  input  logic [INT_W+FRAC_W-1:0]           fcw,
  input  logic [EDGE_W-1:0]                 edgeInc,
  input  logic [FRAC_W-1:0]                 tdcFrac,
  input  logic signed [INT_W+FRAC_W-1:0]    modWord,
  input  logic [SHIFT_W-1:0]                kpShift,
  input  logic [SHIFT_W-1:0]                kiShift,
  input  logic [GAIN_W-1:0]                 invGain,
  output logic [INT_W+FRAC_W-1:0]           phaseErr,
  output logic signed [OTW_W-1:0]           otw
);
  localparam int PH_W = INT_W + FRAC_W;

  loopStb_t                  stb;
  logic                      filtStb;
  logic signed [INTEG_W-1:0] integVal;
  logic [PH_W-1:0]           phErrNow;

  assign filtStb = stb.filt;

  dpll_phase_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .refValid (refValid),
    .stb      (stb)
  );

  dpll_phase_dp #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .EDGE_W(EDGE_W), .SHIFT_W(SHIFT_W),
    .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .INTEG_W(INTEG_W),
    .OTW_W(OTW_W), .OTW_CENTER(OTW_CENTER), .PH_W(PH_W)
  ) u_dp (
    .clk      (clk),
    .stb      (stb),
    .fcw      (fcw),
    .edgeInc  (edgeInc),
    .tdcFrac  (tdcFrac),
    .modWord  (modWord),
    .kpShift  (kpShift),
    .kiShift  (kiShift),
    .invGain  (invGain),
    .phaseErr (phaseErr),
    .otw      (otw),
    .integVal (integVal),
    .phErrNow (phErrNow)
  );
endmodule

// File: rtl/dpll_phase_core_chk.sv
module dpll_phase_core_chk #(
  parameter int PH_W       = 12,
  parameter int GAIN_W     = 8,
  parameter int INTEG_W    = 16,
  parameter int OTW_W      = 14,
  parameter int OTW_CENTER = 256
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      refValid,
  input logic                      filtStb,
  input logic signed [INTEG_W-1:0] integ,
  input logic                      errNeg,
  input logic [GAIN_W-1:0]         invGain,
  input logic signed [OTW_W-1:0]   otw,
  input logic [PH_W-1:0]           phaseErr
);
  localparam logic signed [INTEG_W-1:0] IMAX = INTEG_W'((2**(INTEG_W-1)) - 1);
  localparam logic signed [INTEG_W-1:0] IMIN = INTEG_W'(-(2**(INTEG_W-1)));
  localparam logic signed [OTW_W-1:0]   CTR  = OTW_W'(OTW_CENTER);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (otw == CTR && phaseErr == '0)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(refValid, 2))
      |-> ($stable(otw) && $stable(phaseErr))); // R2

  AST_FILT_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (filtStb == $past(refValid))); // R3

  AST_INTEG_SAT_HI: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(filtStb) && $past(integ) == IMAX && !$past(errNeg))
      |-> (integ == IMAX)); // R8

  AST_INTEG_SAT_LO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(filtStb) && $past(integ) == IMIN && $past(errNeg))
      |-> (integ == IMIN)); // R8

  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(filtStb) && $past(invGain) == '0)
      |-> (otw == CTR)); // R9
endmodule

bind dpll_phase_core dpll_phase_core_chk #(
  .PH_W(PH_W), .GAIN_W(GAIN_W), .INTEG_W(INTEG_W),
  .OTW_W(OTW_W), .OTW_CENTER(OTW_CENTER)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .refValid (refValid),
  .filtStb  (filtStb),
  .integ    (integVal),
  .errNeg   (phErrNow[PH_W-1]),
  .invGain  (invGain),
  .otw      (otw),
  .phaseErr (phaseErr)
);

// File: tb/dpll_phase_core_bench.sv
module dpll_phase_core_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [11:0] fcw;
    logic [3:0]  edges;
    logic [3:0]  tdc;
    logic [11:0] mod;
    logic [2:0]  kp;
    logic [2:0]  ki;
    logic [7:0]  gain;
    logic [11:0] expPe;
  } vec_t;

  // R3/R5/R6/R7/R10 stimulus, cumulative from reset; expPe is the expected phaseErr
  localparam vec_t VECS [8] = '{
    '{12'h010, 4'd1,  4'd0,  12'h000, 3'd2, 3'd4, 8'd16, 12'd0},
    '{12'h028, 4'd2,  4'd8,  12'h000, 3'd1, 3'd3, 8'd16, 12'd16},
    '{12'h028, 4'd3,  4'd0,  12'h000, 3'd0, 3'd2, 8'd32, 12'd0},
    '{12'h018, 4'd1,  4'd5,  12'h000, 3'd3, 3'd1, 8'd8,  12'd13},
    '{12'h030, 4'd4,  4'd0,  12'h000, 3'd2, 3'd0, 8'd16, 12'd4088},
    '{12'h020, 4'd2,  4'd15, 12'hFF0, 3'd1, 3'd2, 8'd24, 12'd4087},
    '{12'h020, 4'd1,  4'd0,  12'h030, 3'd4, 3'd5, 8'd16, 12'd40},
    '{12'h100, 4'd15, 4'd3,  12'h000, 3'd0, 3'd3, 8'd40, 12'd59}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refValid = 1'b0;
  logic [11:0] fcw = '0;
  logic [3:0]  edgeInc = '0;
  logic [3:0]  tdcFrac = '0;
  logic signed [11:0] modWord = '0;
  logic [2:0]  kpShift = '0;
  logic [2:0]  kiShift = '0;
  logic [7:0]  invGain = '0;
  logic [11:0] phaseErr;
  logic signed [13:0] otw;

  int nChecks = 0;
  int nFail = 0;
  int refM = 0, varM = 0, tdcM = 0, modM = 0, integM = 0;
  int expPeM = 0, expOtwM = 256;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpll_phase_core u_dpll_phase_core (
    .clk(clk), .rst(rst), .refValid(refValid), .fcw(fcw), .edgeInc(edgeInc),
    .tdcFrac(tdcFrac), .modWord(modWord), .kpShift(kpShift), .kiShift(kiShift),
    .invGain(invGain), .phaseErr(phaseErr), .otw(otw)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 rst = 1'b0;
    refM = 0; varM = 0; tdcM = 0; modM = 0; integM = 0;
  endtask

  // One reference update, then sample outputs one cycle later
  task automatic step(input int f, input int e, input int t, input int m,
                      input int kp, input int ki, input int g);
    int peS, ctrl, o;
    fcw = f[11:0]; edgeInc = e[3:0]; tdcFrac = t[3:0]; modWord = m[11:0];
    kpShift = kp[2:0]; kiShift = ki[2:0]; invGain = g[7:0];
    refValid = 1'b1;
    @(posedge clk);
    #1 refValid = 1'b0;
    refM = (refM + f + m) & 4095;
    varM = (varM + e) & 255;
    tdcM = t; modM = m;
    @(posedge clk);
    #1;
    expPeM = (refM - varM * 16 + tdcM) & 4095;
    peS = (expPeM >= 2048) ? expPeM - 4096 : expPeM;
    integM = integM + (peS >>> ki);
    if (integM > 32767) integM = 32767;
    if (integM < -32768) integM = -32768;
    ctrl = integM + (peS >>> kp) + modM;
    o = 256 + ((ctrl * g) >>> 4);
    if (o > 8191) o = 8191;
    if (o < -8192) o = -8192;
    expOtwM = o;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int heldOtw, heldPe;
    // R1: reset state, held with no refValid
    doReset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 otw after reset", int'(otw), 256);
    check("R1 phaseErr after reset", int'(phaseErr), 0);

    // Table walk: R3 R5 R6 R7 R10
    foreach (VECS[i]) begin
      step(int'(VECS[i].fcw), int'(VECS[i].edges), int'(VECS[i].tdc),
           int'($signed(VECS[i].mod)), int'(VECS[i].kp), int'(VECS[i].ki),
           int'(VECS[i].gain));
      check("R3/R5 phaseErr table", int'(phaseErr), int'(VECS[i].expPe));
      check("R6/R7/R10 otw table", int'(otw), expOtwM);
    end

    // R2: idle inputs change, outputs and state untouched
    heldOtw = int'(otw);
    heldPe  = int'(phaseErr);
    for (int k = 0; k < 5; k++) begin
      fcw = 12'hABC; edgeInc = 4'd9; tdcFrac = 4'd7; modWord = 12'h123;
      kpShift = 3'd5; kiShift = 3'd0; invGain = 8'd200;
      @(posedge clk);
    end
    #1;
    check("R2 otw idle", int'(otw), heldOtw);
    check("R2 phaseErr idle", int'(phaseErr), heldPe);
    step(16, 1, 2, 0, 2, 3, 16);
    check("R2 accumulators untouched by idle", int'(phaseErr), expPeM);
    check("R2 otw after idle", int'(otw), expOtwM);

    // R11: mid-run reset restores R1 state
    doReset();
    #1;
    check("R11 otw after mid reset", int'(otw), 256);
    check("R11 phaseErr after mid reset", int'(phaseErr), 0);

    // R4: matched rates across several wraps, error stays at tdc value
    for (int k = 0; k < 20; k++) begin
      step(12'h0F0, 15, 3, 0, 3, 7, 16);
      check("R4 phaseErr across wrap", int'(phaseErr), expPeM);
    end
    check("R4 final phaseErr equals fraction", int'(phaseErr), 3);

    // R8: positive integrator saturation, constant error 2032
    doReset();
    step(12'h7F0, 0, 0, 0, 7, 0, 1);
    for (int k = 0; k < 20; k++) step(0, 0, 0, 0, 7, 0, 1);
    check("R8 otw at high integrator limit", int'(otw), 2304);
    step(0, 0, 0, 0, 7, 0, 1);
    check("R8 integrator stays pinned high", int'(otw), 2304);
    // R9: tuning word saturates high
    step(0, 0, 0, 0, 7, 0, 255);
    check("R9 otw high saturation", int'(otw), 8191);
    // R9: zero inverse gain gives centre
    step(0, 0, 0, 0, 7, 0, 0);
    check("R9 zero gain centre", int'(otw), 256);

    // R8: negative saturation, constant error -2032
    doReset();
    step(12'h810, 0, 0, 0, 7, 0, 1);
    for (int k = 0; k < 20; k++) step(0, 0, 0, 0, 7, 0, 1);
    check("R8 otw at low integrator limit", int'(otw), -1793);
    step(0, 0, 0, 0, 7, 0, 255);
    check("R9 otw low saturation", int'(otw), -8192);

    // R10: modulation enters reference and tuning path in one update
    doReset();
    step(0, 0, 0, 32, 0, 7, 16);
    check("R10 phaseErr sees modulation", int'(phaseErr), 32);
    check("R10 otw sees modulation directly", int'(otw), 320);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule